// File: doc/BRIEF.md
# Secure Region Filter Configuration Registers

This block is the software-facing register bank of a filter that splits a memory range into fixed-size blocks and marks each block secure or non-secure. Software programs a bitmap of per-block security bits through a window: an index register picks one 32-bit word of the bitmap and a data register reads or writes that word. When auto-increment is on, the index steps forward after each full-word data access, so a whole bitmap can be streamed with consecutive accesses to the same address. The filter logic reads the bitmap through a separate combinational port. When it rejects a transaction it reports the event on a set of capture inputs.

The bank also holds a latched violation flag, its interrupt enable, and two registers that record the first rejected transaction. A lockdown bit freezes the control, bitmap-data and interrupt-enable registers until the next reset. Access rules follow the secure attribute of each request. A non-secure master sees only the constant identification bytes at the top of the 4 KiB window. Every other offset reads as zero for it, and its writes there have no effect. Accesses may be byte, halfword or word, and each completes in the cycle it is presented.

Top module: `mpc_cfg_regs`

## Requirements
- R1: After reset, control reads 0x00000100, interrupt enable reads 1, and the index, flag, both capture registers and every bitmap word read 0. The irq output is 0.
- R2: Control is at 0x00. Only bits 4 (error-response select), 8 (auto-increment) and 31 (lockdown) hold written values. All other control bits read 0.
- R3: Offset 0x10 reads NUM_WORDS-1 and offset 0x14 reads BLK_LOG2-5.
- R4: A write to the index register at 0x18 stores the written value modulo NUM_WORDS. The index never reaches NUM_WORDS.
- R5: Offset 0x1C reads or writes the bitmap word selected by the index. A full-word access is size code 2 or 3. A full-word secure access there with control bit 8 set advances the index by one, wrapping from NUM_WORDS-1 to 0. Byte (size 0) and halfword (size 1) accesses leave the index unchanged.
- R6: While control bit 31 is set, writes to 0x00, 0x1C and 0x28 have no effect, and an ignored 0x1C write does not advance the index. Only reset clears bit 31.
- R7: A non-secure access (req_secure=0) to an offset below 0xFD0 returns 0 and changes no state. Non-secure reads of 0xFD0 to 0xFFC return the identification bytes.
- R8: Writing bit 0 = 1 to 0x34 sets the violation flag (read at 0x20 bit 0). Writing bit 0 = 1 to 0x24 clears it, and this clear wins over a capture in the same cycle. Bit 0 of 0x28 is the interrupt enable, and irq equals flag AND enable.
- R9: A sub-word write takes its value from the low bits of req_wdata. A byte write lands in lane req_addr[1:0] and a halfword write lands in half req_addr[1]. The rest of the word comes from the current value for 0x00, 0x18 and 0x1C, and is zero for every other register.
- R10: A byte read returns lane req_addr[1:0] of the register word and a halfword read returns half req_addr[1]. Both are right-aligned with zero fill.
- R11: Offsets 0xFD0 through 0xFFC, in ascending order, read the bytes 0x04,0x00,0x00,0x00,0x60,0xB8,0x1B,0x00,0x0D,0xF0,0x05,0xB1. Writes to them are ignored.
- R12: A viol_valid pulse while the flag is 0 sets the flag and records viol_addr in 0x2C. The same pulse records {cfg_ns, nonsec, master[15:0]} in bits 17:0 of 0x30. While the flag is 1, pulses leave both records unchanged.
- R13: lut_rd_word always equals bitmap word lut_rd_idx.
- R14: Reads of 0x24, 0x34 and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, right-aligned for sub-word |
| req_secure | input | 1 | Secure attribute of the access |
| rsp_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Violation interrupt |
| lut_rd_idx | input | IDX_W | Bitmap word selector for the filter |
| lut_rd_word | output | 32 | Selected bitmap word |
| viol_valid | input | 1 | Filter rejected a transaction |
| viol_addr | input | 32 | Address of rejected transaction |
| viol_master | input | 16 | Requester id of rejected transaction |
| viol_nonsec | input | 1 | Rejected transaction was non-secure |
| viol_cfg_ns | input | 1 | Bitmap bit of the rejected block |

## Verification
The assertions assume that req_valid, req_write, req_addr, req_size and req_secure are known whenever the block is out of reset. They also assume that a sub-word access to 0x1C carries a size code of 0 or 1, which the properties use to tell a stepping access from a non-stepping one. The bench drives every input to a defined value at each falling edge and keeps size codes within 0 to 2. It masks bit 31 out of random control writes so that lockdown is entered only in a directed phase. It applies violation pulses independently of register accesses, so same-cycle collisions with set and clear writes do occur.

// File: rtl/mpcreg_pkg.sv
package mpcreg_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTRL, RS_MAX, RS_CFG, RS_IDX, RS_DATA, RS_STAT,
    RS_CLR, RS_EN, RS_INFO1, RS_INFO2, RS_SET, RS_ID
  } reg_sel_e;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'h8000_0110;
  localparam logic [31:0] CTRL_RESET     = 32'h0000_0100;
  localparam int unsigned CTRL_AUTO_BIT  = 8;
  localparam int unsigned CTRL_LOCK_BIT  = 31;

  // Deposit the right-aligned sub-word of new_d into old_w at the addressed lane.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_d,
                                             input logic [1:0]  sz,
                                             input logic [1:0]  lane);
    logic [31:0] r;
    r = old_w;
    case (sz)
      2'd0:    r[int'(lane) * 8 +: 8]     = new_d[7:0];
      2'd1:    r[int'(lane[1]) * 16 +: 16] = new_d[15:0];
      default: r = new_d;
    endcase
    return r;
  endfunction

  // Pull the addressed lane(s) out of a word, right-aligned, zero filled.
  function automatic logic [31:0] lane_extract(input logic [31:0] w,
                                               input logic [1:0]  sz,
                                               input logic [1:0]  lane);
    logic [31:0] s;
    case (sz)
      2'd0: begin
        s = w >> (int'(lane) * 8);
        return {24'h0, s[7:0]};
      end
      2'd1: begin
        s = w >> (int'(lane[1]) * 16);
        return {16'h0, s[15:0]};
      end
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] wrap_index(input logic [31:0] v, input int unsigned n);
    return v % n;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] n);
    case (n)
      4'd0:  return 8'h04;
      4'd4:  return 8'h60;
      4'd5:  return 8'hB8;
      4'd6:  return 8'h1B;
      4'd8:  return 8'h0D;
      4'd9:  return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mpcreg_decode.sv
module mpcreg_decode
  import mpcreg_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        secure,
  output reg_sel_e    sel,
  output logic        ns_denied
);
  always_comb begin
    sel = RS_NONE;
    if (addr[11:2] >= 10'h3F4) begin
      sel = RS_ID;
    end else begin
      case (addr[11:2])
        10'h000: sel = RS_CTRL;
        10'h004: sel = RS_MAX;
        10'h005: sel = RS_CFG;
        10'h006: sel = RS_IDX;
        10'h007: sel = RS_DATA;
        10'h008: sel = RS_STAT;
        10'h009: sel = RS_CLR;
        10'h00A: sel = RS_EN;
        10'h00B: sel = RS_INFO1;
        10'h00C: sel = RS_INFO2;
        10'h00D: sel = RS_SET;
        default: sel = RS_NONE;
      endcase
    end
  end

  assign ns_denied = !secure && (addr[11:2] < 10'h3F4);
endmodule

// File: rtl/mpcreg_table.sv
module mpcreg_table
  import mpcreg_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [31:0]      idx_wval,
  input  logic             data_we,
  input  logic [31:0]      data_wval,
  input  logic             advance,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] idx_q,
  output logic [31:0]      cur_word,
  output logic [31:0]      rd_word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [31:0] words [NUM_WORDS];
  logic [31:0] idx_mod;

  assign idx_mod = wrap_index(idx_wval, NUM_WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= idx_mod[IDX_W-1:0];
    end else if (advance) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (data_we && (32'(idx_q) == g)) begin
        words[g] <= data_wval;
      end
    end
  end

  always_comb begin
    cur_word = '0;
    rd_word  = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (32'(idx_q) == i)  cur_word = words[i];
      if (32'(rd_idx) == i) rd_word  = words[i];
    end
  end
endmodule

// File: rtl/mpcreg_irq.sv
module mpcreg_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_ev,
  input  logic        clr_ev,
  input  logic        en_we,
  input  logic        en_val,
  input  logic        viol_valid,
  input  logic [31:0] viol_addr,
  input  logic [15:0] viol_master,
  input  logic        viol_nonsec,
  input  logic        viol_cfg_ns,
  output logic        stat_q,
  output logic        en_q,
  output logic [31:0] info1_q,
  output logic [31:0] info2_q,
  output logic        capture_ev,
  output logic        irq
);
  assign capture_ev = viol_valid && !stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      en_q    <= 1'b1;
      info1_q <= '0;
      info2_q <= '0;
    end else begin
      if (clr_ev)                       stat_q <= 1'b0;
      else if (set_ev || capture_ev)    stat_q <= 1'b1;
      if (en_we) en_q <= en_val;
      if (capture_ev) begin
        info1_q <= viol_addr;
        info2_q <= {14'h0, viol_cfg_ns, viol_nonsec, viol_master};
      end
    end
  end

  assign irq = stat_q && en_q;
endmodule

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
  import mpcreg_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned BLK_LOG2  = 12,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             req_secure,
  output logic [31:0]      rsp_rdata,
  output logic             irq,
  input  logic [IDX_W-1:0] lut_rd_idx,
  output logic [31:0]      lut_rd_word,
  input  logic             viol_valid,
  input  logic [31:0]      viol_addr,
  input  logic [15:0]      viol_master,
  input  logic             viol_nonsec,
  input  logic             viol_cfg_ns
);
  reg_sel_e         sel;
  logic             ns_denied;
  logic [31:0]      ctrl_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      cur_word;
  logic             stat_q, en_q, capture_ev;
  logic [31:0]      info1_q, info2_q;
  logic [31:0]      merge_base, wval, reg_word;

  // Named internal events
  logic acc_ok, wr_ok, rd_ok, full_word, locked;
  logic ctrl_we, idx_we, data_we, data_rd, advance_ev, en_we, set_ev, clr_ev;

  mpcreg_decode u_dec (
    .addr(req_addr), .secure(req_secure), .sel(sel), .ns_denied(ns_denied)
  );

  assign acc_ok    = req_valid && !ns_denied;
  assign wr_ok     = acc_ok && req_write;
  assign rd_ok     = acc_ok && !req_write;
  assign full_word = req_size[1];
  assign locked    = ctrl_q[CTRL_LOCK_BIT];

  always_comb begin
    case (sel)
      RS_CTRL: merge_base = ctrl_q;
      RS_IDX:  merge_base = 32'(idx_q);
      RS_DATA: merge_base = cur_word;
      default: merge_base = '0;
    endcase
  end

  assign wval = lane_merge(merge_base, req_wdata, req_size, req_addr[1:0]);

  assign ctrl_we    = wr_ok && (sel == RS_CTRL) && !locked;
  assign idx_we     = wr_ok && (sel == RS_IDX);
  assign data_we    = wr_ok && (sel == RS_DATA) && !locked;
  assign data_rd    = rd_ok && (sel == RS_DATA);
  assign advance_ev = (data_we || data_rd) && full_word && ctrl_q[CTRL_AUTO_BIT];
  assign en_we      = wr_ok && (sel == RS_EN) && !locked;
  assign set_ev     = wr_ok && (sel == RS_SET) && wval[0];
  assign clr_ev     = wr_ok && (sel == RS_CLR) && wval[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= wval & CTRL_KEEP_MASK;
  end

  mpcreg_table #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .idx_we(idx_we), .idx_wval(wval),
    .data_we(data_we), .data_wval(wval),
    .advance(advance_ev), .rd_idx(lut_rd_idx),
    .idx_q(idx_q), .cur_word(cur_word), .rd_word(lut_rd_word)
  );

  mpcreg_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_ev(set_ev), .clr_ev(clr_ev), .en_we(en_we), .en_val(wval[0]),
    .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_master(viol_master),
    .viol_nonsec(viol_nonsec), .viol_cfg_ns(viol_cfg_ns),
    .stat_q(stat_q), .en_q(en_q), .info1_q(info1_q), .info2_q(info2_q),
    .capture_ev(capture_ev), .irq(irq)
  );

  always_comb begin
    case (sel)
      RS_CTRL:  reg_word = ctrl_q;
      RS_MAX:   reg_word = 32'(NUM_WORDS - 1);
      RS_CFG:   reg_word = 32'(BLK_LOG2 - 5);
      RS_IDX:   reg_word = 32'(idx_q);
      RS_DATA:  reg_word = cur_word;
      RS_STAT:  reg_word = {31'h0, stat_q};
      RS_EN:    reg_word = {31'h0, en_q};
      RS_INFO1: reg_word = info1_q;
      RS_INFO2: reg_word = info2_q;
      RS_ID:    reg_word = {24'h0, id_byte(req_addr[5:2] - 4'd4)};
      default:  reg_word = '0;
    endcase
  end

  assign rsp_rdata = rd_ok ? lane_extract(reg_word, req_size, req_addr[1:0]) : 32'h0;
endmodule

// File: rtl/mpc_cfg_regs_chk.sv
module mpc_cfg_regs_chk #(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [11:0]      req_addr,
  input logic [1:0]       req_size,
  input logic             req_secure,
  input logic [31:0]      ctrl_q,
  input logic [IDX_W-1:0] idx_q,
  input logic             en_q,
  input logic             stat_q,
  input logic [31:0]      info1_q,
  input logic [31:0]      info2_q,
  input logic             set_ev,
  input logic             clr_ev
);
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < NUM_WORDS);

  p_subword_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_secure && !req_size[1] && req_addr[11:2] == 10'h007) |=> $stable(idx_q));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31] |=> ctrl_q[31]);

  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31] |=> ($stable(ctrl_q) && $stable(en_q)));

  p_ns_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_secure && req_addr < 12'hFD0) |=>
      ($stable(ctrl_q) && $stable(idx_q) && $stable(en_q)));

  p_set_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> stat_q);

  p_clear_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !stat_q);

  p_info_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |=> ($stable(info1_q) && $stable(info2_q)));
endmodule

bind mpc_cfg_regs mpc_cfg_regs_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .req_secure(req_secure), .ctrl_q(ctrl_q), .idx_q(idx_q),
  .en_q(en_q), .stat_q(stat_q), .info1_q(info1_q), .info2_q(info2_q),
  .set_ev(set_ev), .clr_ev(clr_ev)
);

// File: tb/mpc_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module mpc_cfg_regs_tb_top;
  localparam int NW = 5;
  localparam int BL = 12;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata, lut_rd_word;
  logic irq;
  logic [IW-1:0] lut_rd_idx = '0;
  logic viol_valid = 0, viol_nonsec = 0, viol_cfg_ns = 0;
  logic [31:0] viol_addr = '0;
  logic [15:0] viol_master = '0;

  always #2.5 clk = ~clk;

  mpc_cfg_regs #(.NUM_WORDS(NW), .BLK_LOG2(BL)) dut_i (.*);

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [31:0] m_ctrl, m_i1, m_i2;
  int unsigned m_idx;
  logic [31:0] m_lut [NW];
  logic m_stat, m_en;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 32'h100; m_idx = 0; m_stat = 0; m_en = 1; m_i1 = 0; m_i2 = 0;
    for (int i = 0; i < NW; i++) m_lut[i] = 0;
  endtask

  function automatic logic [7:0] idb(input int k);
    logic [7:0] t [12] = '{8'h04,8'h00,8'h00,8'h00,8'h60,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
    return t[k];
  endfunction

  function automatic logic [31:0] word_at(input logic [11:0] off);
    if (off >= 12'hFD0) return {24'h0, idb((int'(off) - 'hFD0) / 4)};
    case (off)
      12'h000: return m_ctrl;
      12'h010: return NW - 1;
      12'h014: return BL - 5;
      12'h018: return m_idx;
      12'h01C: return m_lut[m_idx];
      12'h020: return {31'h0, m_stat};
      12'h028: return {31'h0, m_en};
      12'h02C: return m_i1;
      12'h030: return m_i2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] a);
    if (sz == 0) return (w >> (8 * a)) & 32'hFF;
    if (sz == 1) return (w >> (16 * a[1])) & 32'hFFFF;
    return w;
  endfunction

  function automatic logic [31:0] put(input logic [31:0] old, input logic [31:0] d,
                                      input logic [1:0] sz, input logic [1:0] a);
    logic [31:0] m;
    if (sz == 0) begin m = 32'hFF << (8 * a); return (old & ~m) | ((d & 32'hFF) << (8 * a)); end
    if (sz == 1) begin m = 32'hFFFF << (16 * a[1]); return (old & ~m) | ((d & 32'hFFFF) << (16 * a[1])); end
    return d;
  endfunction

  // One cycle: optional register access plus optional violation pulse.
  task automatic cyc(input string tag, input logic v, input logic w, input logic [11:0] a,
                     input logic [1:0] sz, input logic [31:0] d, input logic s,
                     input logic vv, input logic [31:0] va, input logic [15:0] vm,
                     input logic vn, input logic vc);
    logic [11:0] off;
    logic [31:0] nv, exp;
    logic cap, setw, clrw, adv;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d; req_secure = s;
    viol_valid = vv; viol_addr = va; viol_master = vm; viol_nonsec = vn; viol_cfg_ns = vc;
    lut_rd_idx = IW'($urandom_range(NW - 1));
    #1;
    chk({tag, " R13 port"}, lut_rd_word, m_lut[lut_rd_idx]);
    chk({tag, " R8 irq"}, {31'h0, irq}, {31'h0, m_stat & m_en});
    off = {a[11:2], 2'b00};
    if (v && !w) begin
      exp = (!s && off < 12'hFD0) ? 32'h0 : pick(word_at(off), sz, a[1:0]);
      chk({tag, " rd"}, rsp_rdata, exp);
    end
    // model update
    cap = vv && !m_stat; setw = 0; clrw = 0; adv = 0;
    if (v && (s || off >= 12'hFD0)) begin
      if (w) begin
        nv = put((off == 0) ? m_ctrl : (off == 12'h018) ? m_idx :
                 (off == 12'h01C) ? m_lut[m_idx] : 32'h0, d, sz, a[1:0]);
        case (off)
          12'h000: if (!m_ctrl[31]) m_ctrl = nv & 32'h8000_0110;
          12'h018: m_idx = nv % NW;
          12'h01C: if (!m_ctrl[31]) begin m_lut[m_idx] = nv; adv = sz[1] && m_ctrl[8]; end
          12'h024: clrw = nv[0];
          12'h028: if (!m_ctrl[31]) m_en = nv[0];
          12'h034: setw = nv[0];
          default: ;
        endcase
      end else if (off == 12'h01C) begin
        adv = sz[1] && m_ctrl[8];
      end
    end
    if (adv) m_idx = (m_idx + 1) % NW;
    if (cap) begin m_i1 = va; m_i2 = {14'h0, vc, vn, vm}; end
    if (clrw) m_stat = 0; else if (setw || cap) m_stat = 1;
    @(posedge clk);
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [1:0] sz, input logic s);
    cyc(tag, 1, 0, a, sz, 0, s, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input string tag, input logic [11:0] a, input logic [1:0] sz,
                    input logic [31:0] d, input logic s);
    cyc(tag, 1, 1, a, sz, d, s, 0, 0, 0, 0, 0);
  endtask
  task automatic viol(input string tag, input logic [31:0] va, input logic [15:0] vm,
                      input logic vn, input logic vc);
    cyc(tag, 0, 0, 0, 0, 0, 1, 1, va, vm, vn, vc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; viol_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] offs [16] = '{12'h000,12'h004,12'h010,12'h014,12'h018,12'h01C,12'h01C,12'h020,
                               12'h024,12'h028,12'h02C,12'h030,12'h034,12'h040,12'hFD0,12'hFF0};
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    // R1 reset state
    rd("R1 ctrl", 12'h000, 2, 1);
    rd("R1 en", 12'h028, 2, 1);
    rd("R1 idx", 12'h018, 2, 1);
    rd("R1 stat", 12'h020, 2, 1);
    rd("R1 info1", 12'h02C, 2, 1);
    rd("R1 info2", 12'h030, 2, 1);
    for (int i = 0; i < 4; i++) rd("R1 lut byte", 12'h01C + 12'(i), 0, 1);
    // R3 geometry
    rd("R3 max", 12'h010, 2, 1);
    rd("R3 cfg", 12'h014, 2, 1);
    // R2 control bits
    wr("R2 ctrl", 12'h000, 2, 32'h7FFF_FFFF, 1);
    rd("R2 ctrl rd", 12'h000, 2, 1);
    wr("R2 ctrl", 12'h000, 2, 32'h0000_0100, 1);
    // R4 modulo index
    wr("R4 idx", 12'h018, 2, 32'd7, 1);
    rd("R4 idx rd", 12'h018, 2, 1);
    wr("R4 idx", 12'h018, 2, 32'hFFFF_FFFF, 1);
    rd("R4 idx rd", 12'h018, 2, 1);
    // R5 auto-increment and wrap
    wr("R5 idx", 12'h018, 2, 32'd3, 1);
    wr("R5 data", 12'h01C, 2, 32'hA5A5_0003, 1);
    wr("R5 data", 12'h01C, 2, 32'h1234_0004, 1);
    rd("R5 wrap", 12'h018, 2, 1);
    wr("R5 sub", 12'h01D, 0, 32'h77, 1);
    rd("R5 sub hold", 12'h018, 2, 1);
    wr("R5 idx", 12'h018, 2, 32'd4, 1);
    rd("R5 rd data", 12'h01C, 2, 1);
    rd("R5 rd wrap", 12'h018, 2, 1);
    wr("R5 noinc", 12'h000, 2, 32'h0, 1);
    rd("R5 rd noinc", 12'h01C, 2, 1);
    rd("R5 idx noinc", 12'h018, 2, 1);
    wr("R5 inc on", 12'h000, 2, 32'h100, 1);
    // R9 and R10 sub-word
    wr("R9 ctrl hi byte", 12'h001, 0, 32'h00, 1);
    rd("R9 ctrl", 12'h000, 2, 1);
    wr("R9 ctrl half", 12'h000, 1, 32'h0110, 1);
    rd("R9 ctrl", 12'h000, 2, 1);
    wr("R9 en lane1", 12'h029, 0, 32'hFF, 1);
    rd("R9 en zero", 12'h028, 2, 1);
    wr("R9 en", 12'h028, 2, 32'h1, 1);
    rd("R10 half", 12'h01E, 1, 1);
    rd("R10 byte", 12'h01F, 0, 1);
    // R11 ID bytes, secure and non-secure, write ignored
    for (int k = 0; k < 12; k++) rd("R11 id", 12'hFD0 + 12'(4 * k), 2, k[0]);
    wr("R11 id wr", 12'hFE0, 2, 32'hFF, 1);
    rd("R11 id after wr", 12'hFE0, 2, 1);
    // R7 non-secure
    rd("R7 ns ctrl", 12'h000, 2, 0);
    wr("R7 ns ctrl", 12'h000, 2, 32'h8000_0000, 0);
    wr("R7 ns set", 12'h034, 2, 32'h1, 0);
    rd("R7 ctrl kept", 12'h000, 2, 1);
    rd("R7 stat kept", 12'h020, 2, 1);
    rd("R7 ns data", 12'h01C, 2, 0);
    rd("R7 idx kept", 12'h018, 2, 1);
    // R12 capture, R8 flag
    viol("R12 first", 32'hDEAD_0040, 16'h00A7, 1, 0);
    rd("R12 info1", 12'h02C, 2, 1);
    rd("R12 info2", 12'h030, 2, 1);
    viol("R12 second", 32'h0000_1111, 16'h0001, 0, 1);
    rd("R12 info1 held", 12'h02C, 2, 1);
    rd("R8 stat", 12'h020, 2, 1);
    wr("R8 en off", 12'h028, 2, 32'h0, 1);
    wr("R8 en on", 12'h028, 2, 32'h1, 1);
    cyc("R8 clear vs capture", 1, 1, 12'h024, 2, 32'h1, 1, 1, 32'h55, 16'h2, 0, 1);
    rd("R8 stat clr", 12'h020, 2, 1);
    wr("R8 set", 12'h034, 2, 32'h1, 1);
    wr("R8 clr0", 12'h024, 2, 32'h2, 1);
    rd("R14 clr rd", 12'h024, 2, 1);
    rd("R14 set rd", 12'h034, 2, 1);
    rd("R14 unmapped", 12'h100, 2, 1);
    wr("R8 clr", 12'h024, 2, 32'h1, 1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [1:0] sz;
      logic [31:0] d;
      a = offs[$urandom_range(15)] | 12'($urandom_range(3));
      if (a[11:4] == 8'hFD || a[11:4] == 8'hFF) a[3:2] = 2'($urandom_range(3));
      sz = 2'($urandom_range(2));
      d = $urandom();
      if (a[11:2] == 10'h000) d = d & 32'h7FFF_7F7F;
      cyc("rand", ($urandom_range(3) != 0), $urandom_range(1), a, sz, d,
          ($urandom_range(9) != 0), ($urandom_range(7) == 0), $urandom(),
          16'($urandom()), $urandom_range(1), $urandom_range(1));
    end

    // R6 lockdown
    wr("R6 idx", 12'h018, 2, 32'd1, 1);
    wr("R6 lock", 12'h000, 2, 32'h8000_0100, 1);
    wr("R6 ctrl wr", 12'h000, 2, 32'h0, 1);
    rd("R6 ctrl kept", 12'h000, 2, 1);
    wr("R6 data wr", 12'h01C, 2, 32'hCAFE_F00D, 1);
    rd("R6 idx not adv", 12'h018, 2, 1);
    rd("R6 data kept", 12'h01C, 1, 1);
    wr("R6 en wr", 12'h028, 2, 32'h0, 1);
    rd("R6 en kept", 12'h028, 2, 1);
    wr("R6 idx ok", 12'h018, 2, 32'd2, 1);
    rd("R6 idx moved", 12'h018, 2, 1);
    do_reset();
    rd("R6 R1 after reset", 12'h000, 2, 1);
    rd("R1 en after reset", 12'h028, 2, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule